// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Per-Operand Sign Control

This block multiplies two operands of up to 18 bits and folds each product into a 52-bit running total. The total covers the full 36-bit product range plus 16 guard bits, so roughly 2^15 full-scale products can be summed before the range is exceeded. Each operand has its own control that selects a two's-complement or an unsigned reading. A per-cycle subtract control lets the unit alternate between adding and removing products, as in decimating filters. A load control restarts the sum from the current product.

Work moves through three register stages. The operands are captured first, the product is registered next, and the accumulator is updated last. The sign, subtract and load controls are delayed to match, so the caller presents every control on the same edge as the operands it belongs to. A sticky flag reports when the running total has left the signed 52-bit range, in either direction. One clock enable freezes every register. One asynchronous clear empties them all.

Top module: `mac_unit`

## Requirements
- R1: When `clr` is high, `acc_out` becomes 0 and `ovf` becomes 0 at once, without waiting for a clock edge.
- R2: Operands and controls that are sampled on an enabled edge n change `acc_out` after enabled edge n+2, and not before.
- R3: When `a_signed` is 1, `op_a` is read as two's complement; when it is 0, `op_a` is read as unsigned. `b_signed` does the same for `op_b`.
- R4: With `load`=0 and `sub`=0, the new `acc_out` is the old `acc_out` plus the product. When the product is zero, `acc_out` stays unchanged.
- R5: With `load`=0 and `sub`=1, the new `acc_out` is the old `acc_out` minus the product.
- R6: With `load`=1, the new `acc_out` is the product itself, whatever the old value and whatever `sub` is, and `ovf` returns to 0.
- R7: When the exact sum or difference falls outside the signed 52-bit range [-2^51, 2^51-1], `ovf` rises and `acc_out` keeps the low 52 bits of the result.
- R8: Once `ovf` is set, it stays 1 until a load reaches the accumulator or `clr` is asserted.
- R9: While `en` is low, `acc_out`, `ovf` and all internal stages hold their values, and the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Clock enable for every register |
| op_a | input | 18 | Operand A |
| op_b | input | 18 | Operand B |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_signed | input | 1 | 1: operand B is two's complement |
| sub | input | 1 | 1: subtract the product, 0: add it |
| load | input | 1 | 1: restart the total from the product |
| acc_out | output | 52 | Running total, two's complement |
| ovf | output | 1 | Sticky out-of-range flag |

## Verification
Some rules are checked by the assertions on every cycle: the accumulator and the flag hold while the enable is low, the flag stays set until a load arrives, a zero product leaves the total unchanged, a zero-product load clears both the total and the flag, and the clear empties both outputs. Other behaviour only the bench scenarios can show. This covers the two-edge latency, the four combinations of signed and unsigned reading, the subtract path, and the wrap on leaving the range. A reference model is compared on every clock. Long runs of full-scale unsigned products push the total past the top of the range and then past the bottom.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int A_W         = 18,
  parameter int B_W         = 18,
  parameter int GUARD       = 16,
  parameter int CTRL_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     en,
  input  logic [A_W-1:0]           op_a,
  input  logic [B_W-1:0]           op_b,
  input  logic                     a_signed,
  input  logic                     b_signed,
  input  logic                     sub,
  input  logic                     load,
  output logic [A_W+B_W+GUARD-1:0] acc_out,
  output logic                     ovf
);
  localparam int P_W   = A_W + B_W + 2;
  localparam int ACC_W = A_W + B_W + GUARD;

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           as_use, bs_use, sub_use, ld_use;
  logic signed [P_W-1:0]   prod_w, prod_q;
  logic signed [ACC_W:0]   acc_x, prod_x, sum_x;
  logic [ACC_W-1:0]        acc_q;
  logic                    ovf_q;

  always_ff @(posedge clk or posedge clr)
    if (clr) begin
      a_q <= '0;
      b_q <= '0;
    end else if (en) begin
      a_q <= op_a;
      b_q <= op_b;
    end

  generate
    if (CTRL_STAGES == 0) begin : g_sign_live
      assign as_use = a_signed;
      assign bs_use = b_signed;
    end else begin : g_sign_reg
      logic as_q, bs_q;
      always_ff @(posedge clk or posedge clr)
        if (clr) begin
          as_q <= 1'b0;
          bs_q <= 1'b0;
        end else if (en) begin
          as_q <= a_signed;
          bs_q <= b_signed;
        end
      assign as_use = as_q;
      assign bs_use = bs_q;
    end

    if (CTRL_STAGES == 0) begin : g_ctl_live
      assign sub_use = sub;
      assign ld_use  = load;
    end else begin : g_ctl_reg
      logic [1:0] ctl_q [CTRL_STAGES];
      always_ff @(posedge clk or posedge clr)
        if (clr) begin
          for (int i = 0; i < CTRL_STAGES; i++) ctl_q[i] <= 2'b00;
        end else if (en) begin
          ctl_q[0] <= {sub, load};
          for (int i = 1; i < CTRL_STAGES; i++) ctl_q[i] <= ctl_q[i-1];
        end
      assign sub_use = ctl_q[CTRL_STAGES-1][1];
      assign ld_use  = ctl_q[CTRL_STAGES-1][0];
    end
  endgenerate

  assign prod_w = $signed({as_use & a_q[A_W-1], a_q}) * $signed({bs_use & b_q[B_W-1], b_q});

  always_ff @(posedge clk or posedge clr)
    if (clr)     prod_q <= '0;
    else if (en) prod_q <= prod_w;

  assign acc_x  = {acc_q[ACC_W-1], acc_q};
  assign prod_x = {{(ACC_W+1-P_W){prod_q[P_W-1]}}, prod_q};
  assign sum_x  = sub_use ? acc_x - prod_x : acc_x + prod_x;

  always_ff @(posedge clk or posedge clr)
    if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      if (ld_use) begin
        acc_q <= prod_x[ACC_W-1:0];
        ovf_q <= 1'b0;
      end else begin
        acc_q <= sum_x[ACC_W-1:0];
        ovf_q <= ovf_q | (sum_x[ACC_W] ^ sum_x[ACC_W-1]);
      end
    end

  assign acc_out = acc_q;
  assign ovf     = ovf_q;

  always @(posedge clk)
    if (clr) assert_clear_R1: assert (acc_q == '0 && !ovf_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (clr)
    !en |=> ($stable(acc_q) && $stable(ovf_q)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (clr)
    (ovf_q && !ld_use) |=> ovf_q);

  assert_zero_add_R4: assert property (@(posedge clk) disable iff (clr)
    (en && !ld_use && prod_q == '0) |=> $stable(acc_q));

  assert_load_zero_R6: assert property (@(posedge clk) disable iff (clr)
    (en && ld_use && prod_q == '0) |=> (acc_q == '0 && !ovf_q));
endmodule

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic clk = 1'b0, clr = 1'b1, en = 1'b0;
  logic [17:0] op_a = '0, op_b = '0;
  logic a_signed = 1'b0, b_signed = 1'b0, sub = 1'b0, load = 1'b0;
  logic [51:0] acc_out;
  logic ovf;

  int errors = 0, checks = 0;
  bit done = 0;

  localparam longint MAXV = (64'sd1 <<< 51) - 1;
  localparam longint MINV = -(64'sd1 <<< 51);

  longint m_acc = 0, m_prod = 0, m_pa = 0, m_pb = 0;
  bit m_ovf = 0, m_sub1 = 0, m_ld1 = 0, m_sub2 = 0, m_ld2 = 0;

  always #2.5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .clr(clr), .en(en), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .sub(sub), .load(load),
    .acc_out(acc_out), .ovf(ovf)
  );

  function automatic longint wrap52(longint v);
    longint w = v & ((64'sd1 <<< 52) - 1);
    if (w > MAXV) w = w - (64'sd1 <<< 52);
    return w;
  endfunction

  function automatic longint opval(logic [17:0] v, logic s);
    if (s) return longint'($signed(v));
    return longint'({46'b0, v});
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, longint'($signed(acc_out)), m_acc);
    check(req, longint'(ovf), longint'(m_ovf));
  endtask

  task automatic cyc(logic [17:0] a, logic [17:0] b, logic as, logic bs,
                     logic s, logic l, logic e, string req);
    longint full;
    op_a = a; op_b = b; a_signed = as; b_signed = bs; sub = s; load = l; en = e;
    @(posedge clk);
    if (e) begin
      if (m_ld2) begin
        m_acc = m_prod; m_ovf = 0;
      end else begin
        full = m_sub2 ? m_acc - m_prod : m_acc + m_prod;
        if (full > MAXV || full < MINV) m_ovf = 1;
        m_acc = wrap52(full);
      end
      m_prod = m_pa * m_pb; m_sub2 = m_sub1; m_ld2 = m_ld1;
      m_pa = opval(a, as); m_pb = opval(b, bs); m_sub1 = s; m_ld1 = l;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic model_clear();
    m_acc = 0; m_prod = 0; m_pa = 0; m_pb = 0;
    m_ovf = 0; m_sub1 = 0; m_ld1 = 0; m_sub2 = 0; m_ld2 = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    clr = 1'b0;
    @(negedge clk);

    // R2: latency of two enabled edges
    cyc(18'd3, 18'd5, 0, 0, 0, 1, 1, "R2");
    check("R2", longint'($signed(acc_out)), 0);
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R2");
    check("R2", longint'($signed(acc_out)), 0);
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R2");
    check("R2", longint'($signed(acc_out)), 15);

    // R3 R4 R5 R6: sign modes, add, subtract, load ignoring sub
    cyc(18'h3FFFD, 18'd7, 1, 1, 1, 1, 1, "R6");
    cyc(18'h3FFFF, 18'h3FFFF, 0, 1, 0, 0, 1, "R3");
    cyc(18'd2, 18'd2, 0, 0, 1, 0, 1, "R5");
    cyc(18'h3FFFF, 18'h3FFFF, 1, 0, 0, 0, 1, "R3");
    cyc(18'h3FFFF, 18'h3FFFF, 1, 1, 0, 0, 1, "R4");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R4");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R4");
    check("R3", longint'($signed(acc_out)), -21 - 262143 - 4 - 262143 + 1);

    // R9: enable low, inputs wander
    for (int i = 0; i < 6; i++)
      cyc(18'(i * 977 + 5), 18'(i * 4111 + 9), i[0], i[1], i[0], i[1], 0, "R9");
    check("R9", longint'($signed(acc_out)), -524310);
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R9");
    check("R9", longint'($signed(acc_out)), -524310);

    // R7: overflow past the top of the range
    cyc(18'd0, 18'd0, 0, 0, 0, 1, 1, "R6");
    for (int i = 0; i < 32800; i++)
      cyc(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 1, "R7");
    check("R7", longint'(ovf), 1);
    for (int i = 0; i < 5; i++)
      cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R8");
    check("R8", longint'(ovf), 1);

    // R6: load clears flag
    cyc(18'd0, 18'd0, 0, 0, 0, 1, 1, "R6");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R6");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R6");
    check("R6", longint'(ovf), 0);
    check("R6", longint'($signed(acc_out)), 0);

    // R5 R7: underflow past the bottom
    for (int i = 0; i < 32800; i++)
      cyc(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0, 1, "R5");
    check("R7", longint'(ovf), 1);
    for (int i = 0; i < 4; i++)
      cyc(18'd9, 18'd9, 0, 0, 0, 0, 1, "R8");
    check("R8", longint'(ovf), 1);

    // R1: asynchronous clear between edges
    #1 clr = 1'b1;
    #0.5;
    model_clear();
    compare("R1");
    check("R1", longint'(ovf), 0);
    @(negedge clk);
    clr = 1'b0;
    cyc(18'd11, 18'h3FFFE, 0, 1, 0, 0, 1, "R3");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R3");
    cyc(18'd0, 18'd0, 0, 0, 0, 0, 1, "R3");
    check("R3", longint'($signed(acc_out)), -22);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule